// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block takes two IEEE-754 operands and a 4-bit predicate code, and returns a one-bit condition plus an invalid-operation flag. Both operands share one format. A format input selects single or double precision. In single precision only the low 32 bits of each operand carry data. The block works out which one of four relations holds between the operands: less, equal, greater or unordered. The predicate code then decides whether that relation makes the condition true.

The predicate code has two parts. Its low three bits form a mask over the relations less, equal and unordered, so the eight mask values cover every useful combination. Its top bit marks a signaling predicate. A signaling predicate flags invalid when either operand is any NaN. A quiet predicate flags invalid only when an operand is a signaling NaN.

A 3-bit condition-code index travels with each request and comes out beside the result, so a status register downstream can record the condition in the chosen slot. The comparison is combinational. The result goes out through one register stage that loads only when a request is valid.

Top module: `fcmp_pred_unit`

## Requirements
- R1: When `in_valid` is sampled high at a clock edge, `out_valid` is high after that edge and the result outputs hold that request's result. When `in_valid` is sampled low, `out_valid` is low and `cond_out`, `invalid_out` and `cc_out` keep their previous values.
- R2: The mask in `pred[2:0]` enables relations as follows: bit 0 enables unordered, bit 1 enables equal and bit 2 enables less. `cond_out` is 1 exactly when the relation that holds is enabled. The greater relation never makes the condition true, and mask 0 is always false.
- R3: If either operand is a NaN (exponent all ones, fraction non-zero), the relation is unordered only. Less and equal are then both false.
- R4: Positive zero and negative zero compare equal in every sign combination.
- R5: Ordered operands compare by sign-magnitude value. Between two negative operands, the one with the larger magnitude is less. A negative infinity is less than every finite value, and a positive infinity is greater than every finite value.
- R6: `cc_out` carries the `cc_idx` of the request whose result is on the outputs.
- R7: When `pred[3]` is 1 (signaling predicate) and either operand is any NaN, `invalid_out` is 1.
- R8: When `pred[3]` is 0, `invalid_out` is 1 only if an operand is a signaling NaN, meaning a NaN whose top fraction bit is 0. Quiet NaNs and ordered operands give 0.
- R9: `fmt_dbl` = 1 compares all 64 bits as double precision. `fmt_dbl` = 0 compares `op_a[31:0]` and `op_b[31:0]` as single precision, and the upper 32 bits have no effect.
- R10: While `rst_n` is low at a clock edge, the unit clears `out_valid`, `cond_out`, `invalid_out` and `cc_out` to 0. This reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| pred | input | 4 | Predicate code: [2:0] relation mask, [3] signaling |
| cc_idx | input | 3 | Condition-code slot index passed through with the result |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| cond_out | output | 1 | Condition result |
| invalid_out | output | 1 | Invalid-operation flag |
| cc_out | output | 3 | Condition-code index of the result |

## Verification
The condition result and the invalid flag come from the same operand pair, so both can assert in one result. Three stimuli exercise this:
- A signaling predicate whose mask includes unordered, applied to a NaN operand, must give `cond_out` = 1 and `invalid_out` = 1 together.
- The same NaN under a mask without unordered must give invalid with a false condition.
- A quiet predicate on a quiet NaN must give a true condition with no invalid.

Requests are issued back to back with changing `cc_idx`, so each result cycle is judged against its own request. The scoreboard compares condition, flag and index together.

// File: rtl/fcmp_pkg.sv
// Package: shared widths and the operand classification record for the
// compare predicate unit. Assumes IEEE-754 binary32 and binary64 layouts.
package fcmp_pkg;
    parameter int SP_EXP_W = 8;
    parameter int SP_MAN_W = 23;
    parameter int DP_EXP_W = 11;
    parameter int DP_MAN_W = 52;
    localparam int OPND_W  = 1 + DP_EXP_W + DP_MAN_W;
    localparam int MAG_W   = OPND_W - 1;
    localparam int PRED_W  = 4;
    localparam int CC_W    = 3;

    // Relation mask bit positions inside the predicate code
    localparam int MB_UNORD = 0;
    localparam int MB_EQUAL = 1;
    localparam int MB_LESS  = 2;
    localparam int MB_SIGNL = 3;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } opnd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
// Module: fcmp_classify
// Splits one operand of a given exponent/mantissa width into sign, NaN,
// signaling NaN, zero and a zero-extended magnitude. Assumes the quiet bit
// is the most significant mantissa bit.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] bits_in,
    output opnd_class_t          cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = bits_in[W-2 -: EXP_W];
    assign man_f = bits_in[MAN_W-1:0];

    // Derive classification flags from the field values
    always_comb begin
        cls         = '0;
        cls.sign    = bits_in[W-1];
        cls.is_nan  = (&exp_f) && (|man_f);
        cls.is_snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
        cls.is_zero = (exp_f == '0) && (man_f == '0);
        cls.mag     = MAG_W'(bits_in[W-2:0]);
    end
endmodule

// File: rtl/fcmp_relate.sv
// Module: fcmp_relate
// Decides which relation holds between two classified operands: less,
// equal, unordered, or none of them (greater). Assumes both classes come
// from the same format.
module fcmp_relate
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  opnd_class_t cls_a,
    input  opnd_class_t cls_b,
    output logic        rel_lt,
    output logic        rel_eq,
    output logic        rel_un
);
    logic both_zero;
    logic mag_lt;
    logic mag_gt;
    logic ord_lt;

    // Compare magnitudes once for both directions
    always_comb begin
        mag_lt    = cls_a.mag < cls_b.mag;
        mag_gt    = cls_b.mag < cls_a.mag;
        both_zero = cls_a.is_zero && cls_b.is_zero;
    end

    // Sign-magnitude ordering for non-NaN operands
    always_comb begin
        if (cls_a.sign && !cls_b.sign)
            ord_lt = !both_zero;
        else if (!cls_a.sign && cls_b.sign)
            ord_lt = 1'b0;
        else if (cls_a.sign)
            ord_lt = mag_gt;
        else
            ord_lt = mag_lt;
    end

    // Final relation outputs with unordered dominating
    always_comb begin
        rel_un = cls_a.is_nan || cls_b.is_nan;
        rel_eq = !rel_un && (both_zero ||
                 (cls_a.sign == cls_b.sign && cls_a.mag == cls_b.mag));
        rel_lt = !rel_un && ord_lt;
    end

    p_one_rel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rel_lt, rel_eq, rel_un}));
    p_nan_unord_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_a.is_nan || cls_b.is_nan) |-> (rel_un && !rel_eq && !rel_lt));
    p_zero_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_a.is_zero && cls_b.is_zero) |-> rel_eq);
endmodule

// File: rtl/fcmp_select.sv
// Module: fcmp_select
// Applies the predicate mask to the relation and derives the invalid flag.
// Assumes at most one relation input is high.
module fcmp_select
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRED_W-1:0] pred,
    input  logic              rel_lt,
    input  logic              rel_eq,
    input  logic              rel_un,
    input  logic              any_snan,
    output logic              cond,
    output logic              inv
);
    // Condition from mask and relation; invalid from NaN kind and predicate
    always_comb begin
        cond = (pred[MB_LESS]  && rel_lt) ||
               (pred[MB_EQUAL] && rel_eq) ||
               (pred[MB_UNORD] && rel_un);
        inv  = rel_un && (pred[MB_SIGNL] || any_snan);
    end

    p_sig_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pred[MB_SIGNL] && rel_un) |-> inv);
    p_inv_unord_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv |-> rel_un);
endmodule

// File: rtl/fcmp_pred_unit.sv
// Module: fcmp_pred_unit (top)
// Compares two operands in single or double precision under a 4-bit
// predicate and registers the condition, invalid flag and condition-code
// index. Assumes single-precision operands sit in bits [31:0].
module fcmp_pred_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              fmt_dbl,
    input  logic [PRED_W-1:0] pred,
    input  logic [CC_W-1:0]   cc_idx,
    input  logic [OPND_W-1:0] op_a,
    input  logic [OPND_W-1:0] op_b,
    output logic              out_valid,
    output logic              cond_out,
    output logic              invalid_out,
    output logic [CC_W-1:0]   cc_out
);
    localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;

    logic [OPND_W-1:0] opnd [2];
    opnd_class_t       cls_sp [2];
    opnd_class_t       cls_dp [2];
    opnd_class_t       cls_sel [2];
    logic              rel_lt, rel_eq, rel_un;
    logic              cond_c, inv_c;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
        fcmp_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) i_cls_sp (
            .bits_in (opnd[gi][SP_W-1:0]),
            .cls     (cls_sp[gi])
        );
        fcmp_classify #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) i_cls_dp (
            .bits_in (opnd[gi]),
            .cls     (cls_dp[gi])
        );
        // Pick the classification that matches the format input
        assign cls_sel[gi] = fmt_dbl ? cls_dp[gi] : cls_sp[gi];
    end

    fcmp_relate i_relate (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls_a  (cls_sel[0]),
        .cls_b  (cls_sel[1]),
        .rel_lt (rel_lt),
        .rel_eq (rel_eq),
        .rel_un (rel_un)
    );

    fcmp_select i_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .pred     (pred),
        .rel_lt   (rel_lt),
        .rel_eq   (rel_eq),
        .rel_un   (rel_un),
        .any_snan (cls_sel[0].is_snan || cls_sel[1].is_snan),
        .cond     (cond_c),
        .inv      (inv_c)
    );

    // Output register: loads on a valid request, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            cond_out    <= 1'b0;
            invalid_out <= 1'b0;
            cc_out      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cond_out    <= cond_c;
                invalid_out <= inv_c;
                cc_out      <= cc_idx;
            end
        end
    end

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
        ($stable(cond_out) && $stable(invalid_out) && $stable(cc_out)));
    p_cc_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> (cc_out == $past(cc_idx)));
endmodule

// File: tb/test_fcmp_pred_unit.sv
`timescale 1ns/1ps
module test_fcmp_pred_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic [3:0]  pred = '0;
    logic [2:0]  cc_idx = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid, cond_out, invalid_out;
    logic [2:0]  cc_out;

    int checks = 0;
    int errors = 0;
    logic [4:0] q_exp [$];
    string      q_tag [$];

    always #2 clk = ~clk;

    fcmp_pred_unit i_fcmp_pred_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .pred(pred), .cc_idx(cc_idx), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .cond_out(cond_out),
        .invalid_out(invalid_out), .cc_out(cc_out)
    );

    // Reference: returns {snan_any, code}; code 0 less, 1 equal, 2 greater, 3 unordered
    function automatic logic [2:0] ref_rel(input logic dbl, input logic [63:0] a,
                                           input logic [63:0] b);
        logic [63:0] v [2];
        logic nan [2];
        logic sn [2];
        longint key [2];
        v[0] = a; v[1] = b;
        for (int k = 0; k < 2; k++) begin
            logic s;
            longint m;
            if (dbl) begin
                s = v[k][63];
                m = longint'({1'b0, v[k][62:0]});
                nan[k] = (v[k][62:52] == 11'h7FF) && (v[k][51:0] != 0);
                sn[k]  = nan[k] && !v[k][51];
            end else begin
                s = v[k][31];
                m = longint'(v[k][30:0]);
                nan[k] = (v[k][30:23] == 8'hFF) && (v[k][22:0] != 0);
                sn[k]  = nan[k] && !v[k][22];
            end
            key[k] = s ? -m : m;
        end
        if (nan[0] || nan[1]) return {sn[0] || sn[1], 2'd3};
        if (key[0] < key[1])  return 3'd0;
        if (key[0] == key[1]) return 3'd1;
        return 3'd2;
    endfunction

    task automatic note(input bit ok, input string tag, input string what,
                        input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one request and push its expected {cc, inv, cond}
    task automatic drive(input string tag, input logic dbl, input logic [3:0] p,
                         input logic [2:0] cc, input logic [63:0] a,
                         input logic [63:0] b);
        logic [2:0] r;
        logic c, iv;
        @(negedge clk);
        r  = ref_rel(dbl, a, b);
        c  = (r[1:0] == 2'd0 && p[2]) || (r[1:0] == 2'd1 && p[1]) ||
             (r[1:0] == 2'd3 && p[0]);
        iv = (r[1:0] == 2'd3) && (p[3] || r[2]);
        q_exp.push_back({cc, iv, c});
        q_tag.push_back(tag);
        in_valid = 1'b1; fmt_dbl = dbl; pred = p; cc_idx = cc;
        op_a = a; op_b = b;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = 64'h7FF0_0000_0000_0001; op_b = '0; pred = 4'hF;
        end
    endtask

    // Monitor: compare each result with the oldest expected entry
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_exp.size() == 0) begin
                note(1'b0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                logic [4:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                note({cc_out, invalid_out, cond_out} == e, t,
                     "{cc,inv,cond}", {cc_out, invalid_out, cond_out}, e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        note(1'b0, "R1", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [63:0] S1P = 64'h3F800000, S2P = 64'h40000000;
    localparam logic [63:0] S1N = 64'hBF800000, S2N = 64'hC0000000;
    localparam logic [63:0] SZP = 64'h0, SZN = 64'h80000000;
    localparam logic [63:0] SIP = 64'h7F800000, SIN = 64'hFF800000;
    localparam logic [63:0] SQN = 64'h7FC00000, SSN = 64'h7F800001;
    localparam logic [63:0] D1P = 64'h3FF0000000000000, D2P = 64'h4000000000000000;
    localparam logic [63:0] D3N = 64'hC008000000000000, DIN = 64'hFFF0000000000000;
    localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;

    initial begin
        logic [2:0] held_cc;
        logic       held_c, held_i;
        repeat (3) @(negedge clk);
        // R10: reset state
        note({out_valid, cond_out, invalid_out, cc_out} == 6'b0, "R10",
             "reset outputs", {out_valid, cond_out, invalid_out, cc_out}, 0);
        rst_n = 1'b1;
        // R2: every mask over less / equal / greater operands
        for (int m = 0; m < 8; m++) begin
            drive("R2", 1'b0, 4'(m), 3'(m), S1P, S2P);
            drive("R2", 1'b0, 4'(m), 3'(7 - m), S2P, S2P);
            drive("R2", 1'b0, 4'(m), 3'(m), S2P, S1P);
        end
        // R3: NaN is unordered only
        drive("R3", 1'b0, 4'b0110, 3'd1, SQN, SQN);
        drive("R3", 1'b0, 4'b0001, 3'd2, S1P, SQN);
        // R4: signed zeros equal
        drive("R4", 1'b0, 4'b0010, 3'd3, SZP, SZN);
        drive("R4", 1'b0, 4'b0100, 3'd4, SZN, SZP);
        drive("R4", 1'b1, 4'b0010, 3'd5, 64'h8000000000000000, 64'h0);
        // R5: negatives and infinities
        drive("R5", 1'b0, 4'b0100, 3'd6, S2N, S1N);
        drive("R5", 1'b0, 4'b0100, 3'd7, S1N, S2N);
        drive("R5", 1'b0, 4'b0100, 3'd0, SIN, S2N);
        drive("R5", 1'b0, 4'b0100, 3'd1, S2P, SIP);
        drive("R5", 1'b0, 4'b0100, 3'd2, SIP, SIN);
        drive("R5", 1'b1, 4'b0100, 3'd3, DIN, D3N);
        // R7: signaling predicate with NaN, condition and invalid together
        drive("R7", 1'b0, 4'b1001, 3'd4, SQN, S1P);
        drive("R7", 1'b0, 4'b1110, 3'd5, S1P, SQN);
        drive("R7", 1'b1, 4'b1011, 3'd6, DQN, D1P);
        // R8: quiet predicate
        drive("R8", 1'b0, 4'b0001, 3'd7, SQN, S1P);
        drive("R8", 1'b0, 4'b0001, 3'd0, S1P, SSN);
        drive("R8", 1'b1, 4'b0000, 3'd1, DSN, D2P);
        drive("R8", 1'b1, 4'b0111, 3'd2, DQN, DQN);
        // R9: single ignores upper bits; double uses them
        drive("R9", 1'b0, 4'b0010, 3'd3, {32'h7FF80000, 32'h3F800000},
              {32'h12345678, 32'h3F800000});
        drive("R9", 1'b1, 4'b0100, 3'd4, D1P, D2P);
        drive("R9", 1'b1, 4'b0010, 3'd5, {32'h3FF00000, 32'h1}, D1P);
        // R6: index follows back-to-back requests
        drive("R6", 1'b0, 4'b0010, 3'd7, S1P, S1P);
        drive("R6", 1'b0, 4'b0010, 3'd0, S1P, S1P);
        // R1: hold while idle after a known result (NaN with signaling predicate)
        drive("R1", 1'b0, 4'b1001, 3'd6, SSN, S1P);
        idle(1);
        @(negedge clk);
        held_cc = cc_out; held_c = cond_out; held_i = invalid_out;
        note({held_cc, held_i, held_c} == 5'b11011, "R1", "result before idle",
             {held_cc, held_i, held_c}, 5'b11011);
        idle(3);
        @(negedge clk);
        note(!out_valid, "R1", "out_valid while idle", out_valid, 0);
        note({cc_out, invalid_out, cond_out} == {held_cc, held_i, held_c}, "R1",
             "held outputs", {cc_out, invalid_out, cond_out},
             {held_cc, held_i, held_c});
        note(q_exp.size() == 0, "R1", "pending results", q_exp.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule